// File: doc/BRIEF.md
# Load Address-Form Latency Classifier

This block sits in the load pipeline of an out-of-order core, between operand decode and the data-return path. Each cycle it can take one decoded memory operand: base-register and index-register presence flags, the two register numbers, a 2-bit scale code and a signed displacement. It also takes a per-register vector from the rename stage that marks registers last written by a recognized zeroing idiom. From these it decides whether the access is a simple or a complex address form, and so how many cycles the load needs before its result may be used. It does not compute the address.

The operand, its sequence tag and the chosen latency then travel through a delay line and appear at the output exactly that many cycles after acceptance, under a valid/ready handshake. Simple operands enter the delay line one stage later than complex ones, so a single shift structure produces both latencies. A small controller with three states tracks the line. In IDLE the line is empty. In RUN entries are moving. In HOLD the output has been refused. The transitions are:
- IDLE to RUN on an accept.
- RUN to HOLD when the output is refused.
- RUN to IDLE when the line drains.
- HOLD to RUN, or to IDLE, when the output is taken.

Top module: `load_lat_classifier`

## Requirements
- R1: An operand with a base register, no index register and a displacement between 0 and 2047 inclusive is simple and is given latency 4 (`out_lat` = 4).
- R2: Every other form is complex and is given latency 5, unless R3 applies. This includes base plus index, an index with no base, no register at all, a negative displacement, and a displacement of 2048 or more.
- R3: An operand whose index register has its bit set in `zero_tag` is given latency 4 whatever its other fields. A set bit for the base register, or for any other register, has no effect. `zero_tag` is read only in the cycle the operand is accepted, and later changes do not alter that operand's latency. A register cleared by moving an immediate zero arrives with its bit clear, so it gets no exemption.
- R4: The exemption looks only at `in_idx_reg`, the register that takes the multiplier 1, 2, 4 or 8 (scale code 0, 1, 2, 3). When a form has two unscaled registers, the second one is placed in `in_idx_reg`. The scale code never changes the latency.
- R5: While `out_ready` is held high, an operand accepted in cycle c is presented with `out_valid` high in cycle c + `out_lat`.
- R6: Results leave in acceptance order and carry their tag, flags, register numbers, scale and displacement unchanged.
- R7: While `out_valid` is high and `out_ready` is low, every output holds its value, the line does not move and `in_ready` is low.
- R8: A latency-4 operand offered in the cycle after a latency-5 operand was accepted is refused (`in_ready` low) because both would reach the output together. A latency-5 operand in that cycle is accepted.
- R9: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand accepted when high with in_valid |
| in_tag | input | TAG_W | Sequence tag of the load |
| in_has_base | input | 1 | Base register present |
| in_base_reg | input | RW | Base register number |
| in_has_idx | input | 1 | Index register present |
| in_idx_reg | input | RW | Index register number (the scaled one, or the second of two unscaled) |
| in_scale | input | 2 | Scale code, multiplier 1 << code |
| in_disp | input | DISP_W | Signed displacement |
| zero_tag | input | NREG | Per-register zeroing-idiom marks from rename |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_tag | output | TAG_W | Tag of the result |
| out_has_base | output | 1 | Base present, passed through |
| out_base_reg | output | RW | Base register, passed through |
| out_has_idx | output | 1 | Index present, passed through |
| out_idx_reg | output | RW | Index register, passed through |
| out_scale | output | 2 | Scale code, passed through |
| out_disp | output | DISP_W | Displacement, passed through |
| out_lat | output | LAT_W | Chosen latency in cycles |

## Verification
The bench targets the edges of the offset window: 0 and 2047 must give 4, while 2048 and -1 must give 5. A comparison that is off by one or unsigned would flip one of these. It sets the zero mark on the base register rather than the index, changes the marks right after acceptance, and varies the scale code. A design that read the wrong register or sampled the marks late would then report the wrong latency. It offers a simple operand directly behind a complex one, where a missing refusal would merge two entries or drop one. It also holds the output refused, where a leaky stall would change the presented tag or take new work. Random traffic with fixed-seed stimulus, checked against a bench model of latency, order and exact arrival cycle, covers the mix.

// File: rtl/ldlat_pkg.sv
package ldlat_pkg;

    // Occupancy and back-pressure condition of the delay line.
    typedef enum logic [1:0] {
        FC_IDLE = 2'd0,   // no entry in flight
        FC_RUN  = 2'd1,   // entries moving toward the output
        FC_HOLD = 2'd2    // output presented and refused last cycle
    } fc_state_e;

endpackage

// File: rtl/ldlat_mode_decode.sv
module ldlat_mode_decode #(
    parameter int NREG        = 16,
    parameter int DISP_W      = 32,
    parameter int OFF_MAX     = 2047,
    parameter int LAT_SIMPLE  = 4,
    parameter int LAT_COMPLEX = 5,
    parameter int RW          = $clog2(NREG),
    parameter int LAT_W       = $clog2(LAT_COMPLEX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              has_base,
    input  logic              has_idx,
    input  logic [RW-1:0]     idx_reg,
    input  logic [DISP_W-1:0] disp,
    input  logic [NREG-1:0]   zero_tag,
    output logic              form_simple,
    output logic              idx_exempt,
    output logic [LAT_W-1:0]  lat
);
    localparam logic [DISP_W-1:0] OFF_LIMIT = DISP_W'(OFF_MAX);
    localparam logic [LAT_W-1:0]  L_FAST    = LAT_W'(LAT_SIMPLE);
    localparam logic [LAT_W-1:0]  L_SLOW    = LAT_W'(LAT_COMPLEX);

    logic off_in_window;

    // Offset must be non-negative and no larger than the window limit.
    assign off_in_window = !disp[DISP_W-1] && (disp <= OFF_LIMIT);

    // Single base register plus in-window offset, nothing else.
    assign form_simple = has_base && !has_idx && off_in_window;

    // Index last written by a zeroing idiom removes the extra cycle.
    assign idx_exempt = has_idx && zero_tag[idx_reg];

    always_comb begin
        if (form_simple || idx_exempt) begin
            lat = L_FAST;
        end else begin
            lat = L_SLOW;
        end
    end

    // R2
    two_reg_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (has_base && has_idx && !zero_tag[idx_reg]) |-> (lat == L_SLOW));

    // R3
    zero_idx_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (has_idx && zero_tag[idx_reg]) |-> (lat == L_FAST));

    // R1
    base_zero_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (has_base && !has_idx && disp == '0) |-> (lat == L_FAST));

endmodule

// File: rtl/ldlat_flow_ctrl.sv
module ldlat_flow_ctrl
    import ldlat_pkg::*;
#(
    parameter int DEPTH = 5,
    parameter int SW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] pipe_v,
    input  logic [SW-1:0]    wr_stage,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             advance,
    output logic             in_ready,
    output fc_state_e        state
);
    fc_state_e state_nxt;
    logic      slot_busy;
    logic      out_v;
    logic      accept;
    logic      busy_after;

    assign out_v  = pipe_v[DEPTH-1];
    assign accept = in_valid && in_ready;

    // Entry stage k is blocked if stage k-1 holds an entry that shifts into it.
    always_comb begin
        slot_busy = 1'b0;
        for (int k = 1; k < DEPTH; k++) begin
            if (int'(wr_stage) == k && pipe_v[k-1]) begin
                slot_busy = 1'b1;
            end
        end
    end

    // Anything left in the line after one move.
    assign busy_after = (|pipe_v[DEPTH-2:0]) || accept;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FC_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state.
    always_comb begin
        state_nxt = state;
        unique case (state)
            FC_IDLE: begin
                if (accept) begin
                    state_nxt = FC_RUN;
                end
            end
            FC_RUN: begin
                if (out_v && !out_ready) begin
                    state_nxt = FC_HOLD;
                end else if (busy_after) begin
                    state_nxt = FC_RUN;
                end else begin
                    state_nxt = FC_IDLE;
                end
            end
            FC_HOLD: begin
                if (out_ready) begin
                    state_nxt = busy_after ? FC_RUN : FC_IDLE;
                end
            end
            default: state_nxt = FC_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        advance  = 1'b1;
        in_ready = 1'b1;
        unique case (state)
            FC_IDLE: begin
                advance  = 1'b1;
                in_ready = !slot_busy;
            end
            FC_RUN: begin
                advance  = !(out_v && !out_ready);
                in_ready = advance && !slot_busy;
            end
            FC_HOLD: begin
                advance  = out_ready;
                in_ready = out_ready && !slot_busy;
            end
            default: begin
                advance  = 1'b0;
                in_ready = 1'b0;
            end
        endcase
    end

    // R7
    hold_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FC_HOLD) |-> out_v);

    // R9
    idle_means_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FC_IDLE) |-> (pipe_v == '0));

    // R7
    no_take_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v && !out_ready) |-> !in_ready);

endmodule

// File: rtl/ldlat_delay_line.sv
module ldlat_delay_line #(
    parameter int DEPTH = 5,
    parameter int PW    = 8,
    parameter int SW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_stage,
    input  logic [PW-1:0]    wr_data,
    output logic [DEPTH-1:0] v_o,
    output logic [PW-1:0]    out_data
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic          v_r;
        logic [PW-1:0] d_r;
        logic          hit;

        assign hit    = wr_en && (int'(wr_stage) == g);
        assign v_o[g] = v_r;

        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_r <= 1'b0;
                end else if (advance) begin
                    v_r <= hit;
                end
            end
            always_ff @(posedge clk) begin
                if (advance && hit) begin
                    d_r <= wr_data;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_r <= 1'b0;
                end else if (advance) begin
                    v_r <= g_stage[g-1].v_r || hit;
                end
            end
            always_ff @(posedge clk) begin
                if (advance) begin
                    d_r <= hit ? wr_data : g_stage[g-1].d_r;
                end
            end
        end
    end

    assign out_data = g_stage[DEPTH-1].d_r;

    // R8
    no_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_stage != '0) |-> !v_o[wr_stage - SW'(1)]);

    // R7
    write_needs_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> advance);

endmodule

// File: rtl/load_lat_classifier.sv
module load_lat_classifier
    import ldlat_pkg::*;
#(
    parameter int NREG        = 16,
    parameter int TAG_W       = 4,
    parameter int DISP_W      = 32,
    parameter int OFF_MAX     = 2047,
    parameter int LAT_SIMPLE  = 4,
    parameter int LAT_COMPLEX = 5,
    parameter int RW          = $clog2(NREG),
    parameter int LAT_W       = $clog2(LAT_COMPLEX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              in_has_base,
    input  logic [RW-1:0]     in_base_reg,
    input  logic              in_has_idx,
    input  logic [RW-1:0]     in_idx_reg,
    input  logic [1:0]        in_scale,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [NREG-1:0]   zero_tag,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_has_base,
    output logic [RW-1:0]     out_base_reg,
    output logic              out_has_idx,
    output logic [RW-1:0]     out_idx_reg,
    output logic [1:0]        out_scale,
    output logic [DISP_W-1:0] out_disp,
    output logic [LAT_W-1:0]  out_lat
);
    localparam int DEPTH = LAT_COMPLEX;
    localparam int SW    = $clog2(DEPTH);
    localparam int PW    = TAG_W + 1 + RW + 1 + RW + 2 + DISP_W + LAT_W;

    logic             form_simple;
    logic             idx_exempt;
    logic [LAT_W-1:0] lat_cls;
    logic [SW-1:0]    wr_stage;
    logic [DEPTH-1:0] pipe_v;
    logic             advance;
    logic             wr_en;
    logic [PW-1:0]    wr_data;
    logic [PW-1:0]    rd_data;
    fc_state_e        fc_state;

    ldlat_mode_decode #(
        .NREG        (NREG),
        .DISP_W      (DISP_W),
        .OFF_MAX     (OFF_MAX),
        .LAT_SIMPLE  (LAT_SIMPLE),
        .LAT_COMPLEX (LAT_COMPLEX),
        .RW          (RW),
        .LAT_W       (LAT_W)
    ) u_decode (
        .clk         (clk),
        .rst_n       (rst_n),
        .has_base    (in_has_base),
        .has_idx     (in_has_idx),
        .idx_reg     (in_idx_reg),
        .disp        (in_disp),
        .zero_tag    (zero_tag),
        .form_simple (form_simple),
        .idx_exempt  (idx_exempt),
        .lat         (lat_cls)
    );

    // Shorter latency enters further down the line.
    assign wr_stage = SW'(LAT_W'(DEPTH) - lat_cls);

    ldlat_flow_ctrl #(
        .DEPTH (DEPTH),
        .SW    (SW)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_v    (pipe_v),
        .wr_stage  (wr_stage),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .advance   (advance),
        .in_ready  (in_ready),
        .state     (fc_state)
    );

    assign wr_en   = in_valid && in_ready;
    assign wr_data = {in_tag, in_has_base, in_base_reg, in_has_idx, in_idx_reg,
                      in_scale, in_disp, lat_cls};

    ldlat_delay_line #(
        .DEPTH (DEPTH),
        .PW    (PW),
        .SW    (SW)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .wr_en    (wr_en),
        .wr_stage (wr_stage),
        .wr_data  (wr_data),
        .v_o      (pipe_v),
        .out_data (rd_data)
    );

    assign out_valid = pipe_v[DEPTH-1];
    assign {out_tag, out_has_base, out_base_reg, out_has_idx, out_idx_reg,
            out_scale, out_disp, out_lat} = rd_data;

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tag)
                                       && $stable(out_lat) && $stable(out_disp)));

    // R1
    fast_path_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (form_simple || idx_exempt)) |-> (wr_stage == SW'(DEPTH - LAT_SIMPLE)));

endmodule

// File: tb/load_lat_classifier_test.sv
`timescale 1ns/100ps
module load_lat_classifier_test;
    localparam int NREG   = 16;
    localparam int TAG_W  = 4;
    localparam int DISP_W = 32;
    localparam int RW     = 4;
    localparam int LAT_W  = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [TAG_W-1:0]  in_tag;
    logic              in_has_base;
    logic [RW-1:0]     in_base_reg;
    logic              in_has_idx;
    logic [RW-1:0]     in_idx_reg;
    logic [1:0]        in_scale;
    logic [DISP_W-1:0] in_disp;
    logic [NREG-1:0]   zero_tag;
    logic              out_valid;
    logic              out_ready;
    logic [TAG_W-1:0]  out_tag;
    logic              out_has_base;
    logic [RW-1:0]     out_base_reg;
    logic              out_has_idx;
    logic [RW-1:0]     out_idx_reg;
    logic [1:0]        out_scale;
    logic [DISP_W-1:0] out_disp;
    logic [LAT_W-1:0]  out_lat;

    load_lat_classifier #(.NREG(NREG), .TAG_W(TAG_W), .DISP_W(DISP_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_has_base(in_has_base), .in_base_reg(in_base_reg),
        .in_has_idx(in_has_idx), .in_idx_reg(in_idx_reg), .in_scale(in_scale),
        .in_disp(in_disp), .zero_tag(zero_tag), .out_valid(out_valid),
        .out_ready(out_ready), .out_tag(out_tag), .out_has_base(out_has_base),
        .out_base_reg(out_base_reg), .out_has_idx(out_has_idx),
        .out_idx_reg(out_idx_reg), .out_scale(out_scale), .out_disp(out_disp),
        .out_lat(out_lat)
    );

    typedef struct {
        logic [TAG_W-1:0]  tag;
        logic              hb;
        logic [RW-1:0]     br;
        logic              hi;
        logic [RW-1:0]     ir;
        logic [1:0]        sc;
        logic [DISP_W-1:0] d;
        int                lat;
        int                acc;
        string             req;
    } exp_t;

    exp_t   q[$];
    int     n_chk = 0;
    int     n_bad = 0;
    int     cyc = 0;
    bit     strict = 1'b1;
    bit     acc_last = 1'b0;
    bit     done = 1'b0;
    string  req_ovr = "";
    logic [TAG_W-1:0] tag_ctr = '0;
    logic [TAG_W-1:0] held_tag;

    // Latency from R1..R3.
    function automatic int model_lat(logic hb, logic hi, logic [RW-1:0] ir,
                                     logic [DISP_W-1:0] d, logic [NREG-1:0] zt);
        if (hb && !hi && $signed(d) >= 0 && $signed(d) <= 2047) return 4;
        if (hi && zt[ir]) return 4;
        return 5;
    endfunction

    function automatic string model_req(logic hb, logic hi, logic [RW-1:0] ir,
                                        logic [DISP_W-1:0] d, logic [NREG-1:0] zt);
        if (hb && !hi && $signed(d) >= 0 && $signed(d) <= 2047) return "R1";
        if (hi && zt[ir]) return "R3";
        return "R2";
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // One cycle: sample before the edge, update the model, move to next negedge.
    task automatic tick();
        exp_t e;
        #0.5;
        acc_last = 1'b0;
        if (out_valid && out_ready) begin
            if (q.size() == 0) begin
                check(1'b0, "R6", "output with nothing pending", out_tag, 0);
            end else begin
                e = q.pop_front();
                check(int'(out_lat) == e.lat, e.req, "latency", out_lat, e.lat);
                check(out_tag == e.tag, "R6", "tag order", out_tag, e.tag);
                check(out_disp == e.d, "R6", "displacement", out_disp, e.d);
                check({out_has_base, out_base_reg, out_has_idx, out_idx_reg, out_scale}
                      == {e.hb, e.br, e.hi, e.ir, e.sc}, "R6", "operand fields",
                      {out_has_base, out_base_reg, out_has_idx, out_idx_reg, out_scale},
                      {e.hb, e.br, e.hi, e.ir, e.sc});
                if (strict)
                    check(cyc == e.acc + e.lat, "R5", "arrival cycle", cyc, e.acc + e.lat);
                else
                    check(cyc >= e.acc + e.lat, "R5", "arrival not early", cyc, e.acc + e.lat);
            end
        end
        if (in_valid && in_ready) begin
            e.tag = in_tag; e.hb = in_has_base; e.br = in_base_reg;
            e.hi = in_has_idx; e.ir = in_idx_reg; e.sc = in_scale; e.d = in_disp;
            e.lat = model_lat(in_has_base, in_has_idx, in_idx_reg, in_disp, zero_tag);
            e.req = (req_ovr != "") ? req_ovr
                  : model_req(in_has_base, in_has_idx, in_idx_reg, in_disp, zero_tag);
            e.acc = cyc;
            q.push_back(e);
            acc_last = 1'b1;
            tag_ctr++;
        end
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic set_op(logic hb, logic [RW-1:0] br, logic hi, logic [RW-1:0] ir,
                          logic [1:0] sc, logic [DISP_W-1:0] d, logic [NREG-1:0] zt);
        in_valid = 1'b1; in_tag = tag_ctr;
        in_has_base = hb; in_base_reg = br; in_has_idx = hi; in_idx_reg = ir;
        in_scale = sc; in_disp = d; zero_tag = zt;
    endtask

    // Offer one operand on an empty line, then let it drain.
    task automatic offer(logic hb, logic [RW-1:0] br, logic hi, logic [RW-1:0] ir,
                         logic [1:0] sc, logic [DISP_W-1:0] d, logic [NREG-1:0] zt,
                         string req);
        set_op(hb, br, hi, ir, sc, d, zt);
        req_ovr = req;
        tick();
        check(acc_last, "R9", "accept on empty line", acc_last, 1);
        in_valid = 1'b0;
        req_ovr = "";
        repeat (6) tick();
    endtask

    task automatic rand_op();
        int k;
        logic [DISP_W-1:0] d;
        k = int'($urandom % 6);
        case (k)
            0: d = '0;
            1: d = DISP_W'(2047);
            2: d = DISP_W'(2048);
            3: d = '1;
            4: d = DISP_W'($urandom % 2048);
            default: d = $urandom;
        endcase
        set_op(1'($urandom), RW'($urandom), 1'($urandom), RW'($urandom),
               2'($urandom), d, NREG'($urandom));
    endtask

    initial begin
        void'($urandom(32'd731));
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_tag = '0; in_has_base = 1'b0; in_base_reg = '0; in_has_idx = 1'b0;
        in_idx_reg = '0; in_scale = '0; in_disp = '0; zero_tag = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.2;
        // R9 reset state
        check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);

        // R1 window edges
        offer(1, 4'd2, 0, 4'd0, 2'd0, 32'd0, '0, "R1");
        offer(1, 4'd2, 0, 4'd0, 2'd0, 32'd2047, '0, "R1");
        // R2 forms outside the window or with extra registers
        offer(1, 4'd2, 0, 4'd0, 2'd0, 32'd2048, '0, "R2");
        offer(1, 4'd2, 0, 4'd0, 2'd0, 32'hFFFF_FFFF, '0, "R2");
        offer(1, 4'd2, 1, 4'd5, 2'd0, 32'd0, '0, "R2");
        offer(0, 4'd0, 1, 4'd5, 2'd2, 32'd16, '0, "R2");
        offer(0, 4'd0, 0, 4'd0, 2'd0, 32'd100, '0, "R2");
        // R3 zero-marked index exempts; mark on base register does not
        offer(1, 4'd2, 1, 4'd5, 2'd0, 32'd0, 16'h0020, "R3");
        offer(1, 4'd2, 1, 4'd5, 2'd0, 32'd8, 16'h0004, "R3");
        offer(0, 4'd0, 1, 4'd7, 2'd1, 32'hFFFF_FFF0, 16'h0080, "R3");
        // R4 scale code has no effect; second unscaled register sits in index field
        offer(1, 4'd1, 1, 4'd9, 2'd3, 32'd64, 16'h0200, "R4");
        offer(1, 4'd9, 1, 4'd1, 2'd0, 32'd64, 16'h0200, "R4");
        offer(1, 4'd3, 1, 4'd6, 2'd3, 32'd64, 16'h0000, "R4");

        // R3 mark sampled at acceptance only
        set_op(1, 4'd2, 1, 4'd3, 2'd0, 32'd4, 16'h0008);
        req_ovr = "R3";
        tick();
        in_valid = 1'b0; req_ovr = ""; zero_tag = '0;
        repeat (6) tick();

        // R8 simple right behind complex is refused, then taken a cycle later
        set_op(1, 4'd2, 1, 4'd3, 2'd0, 32'd4, '0);
        tick();
        set_op(1, 4'd2, 0, 4'd0, 2'd0, 32'd8, '0);
        #0.2;
        check(in_ready == 1'b0, "R8", "simple after complex refused", in_ready, 0);
        tick();
        check(acc_last == 1'b0, "R8", "no accept on collision", acc_last, 0);
        tick();
        check(acc_last == 1'b1, "R8", "accept one cycle later", acc_last, 1);
        in_valid = 1'b0;
        repeat (6) tick();
        // R8 complex behind complex is accepted
        set_op(1, 4'd2, 1, 4'd3, 2'd0, 32'd4, '0);
        tick();
        set_op(0, 4'd0, 1, 4'd4, 2'd1, 32'd4, '0);
        #0.2;
        check(in_ready == 1'b1, "R8", "complex after complex taken", in_ready, 1);
        tick();
        in_valid = 1'b0;
        repeat (7) tick();

        // R7 output refused: hold and refuse input
        strict = 1'b0;
        out_ready = 1'b0;
        set_op(1, 4'd2, 0, 4'd0, 2'd0, 32'd12, '0);
        tick();
        in_valid = 1'b0;
        repeat (5) tick();
        held_tag = out_tag;
        set_op(1, 4'd6, 0, 4'd0, 2'd0, 32'd20, '0);
        #0.2;
        check(out_valid == 1'b1, "R7", "valid held", out_valid, 1);
        check(in_ready == 1'b0, "R7", "input refused in stall", in_ready, 0);
        repeat (3) tick();
        #0.2;
        check(out_tag == held_tag, "R7", "tag stable in stall", out_tag, held_tag);
        check(out_valid == 1'b1, "R7", "valid still held", out_valid, 1);
        out_ready = 1'b1;
        tick();
        while (!acc_last) tick();
        in_valid = 1'b0;
        repeat (8) tick();

        // Random traffic with back-pressure
        for (int i = 0; i < 3000; i++) begin
            if (!in_valid || acc_last) begin
                if ($urandom % 100 < 60) rand_op();
                else in_valid = 1'b0;
            end
            zero_tag = NREG'($urandom);
            out_ready = ($urandom % 4) != 0;
            tick();
        end
        in_valid = 1'b0; out_ready = 1'b1;
        repeat (12) tick();

        // Random traffic, consumer always ready: exact arrival cycles
        strict = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            if (!in_valid || acc_last) begin
                if ($urandom % 100 < 70) rand_op();
                else in_valid = 1'b0;
            end
            zero_tag = NREG'($urandom);
            tick();
        end
        in_valid = 1'b0;
        repeat (12) tick();
        check(q.size() == 0, "R6", "all results delivered", q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule